// File: doc/BRIEF.md
# Byte ALU with Register-Mapped Flag

This block is the register-to-register arithmetic unit of a small 8-bit virtual machine that has sixteen general registers. The surrounding core reads the two source registers (the destination X and the source Y) from its register file. It passes their values to the ALU together with the 4-bit operation selector, which comes from the lowest nibble of the instruction, and the index of X. One clock later the ALU returns a write request for register X and a separate write request for the flag register, which is general register 15.

The flag follows a convention of its own. For both subtractions it reads 1 when no borrow happened. Both shifts take their operand from Y, not from X. Selector values outside the supported set are accepted but change nothing. When X is itself register 15 and the operation produces a flag, only the flag write is issued, so the flag is the value that register 15 ends up holding.

The input is a valid-only stream. The block takes one operation in every cycle that `op_valid` is high and never applies back-pressure. There is no ready signal, because a register-file commit cannot stall. The output side is a one-cycle pulse that the register file must accept in the cycle it appears.

Top module: `byte_alu`

## Requirements
- R1: Selector 0x0 writes Y to X, 0x1 writes X OR Y, 0x2 writes X AND Y, 0x3 writes X XOR Y; none of these four raises `flag_we`.
- R2: Selector 0x4 writes (X + Y) mod 256 and writes flag 0x01 if the sum exceeded 255, else 0x00.
- R3: Selector 0x5 writes (X − Y) mod 256 and writes flag 0x01 when X ≥ Y (no borrow), else 0x00.
- R4: Selector 0x7 writes (Y − X) mod 256 and writes flag 0x01 when Y ≥ X, else 0x00.
- R5: Selector 0x6 writes Y shifted right by one (zero fill) and writes flag equal to bit 0 of Y.
- R6: Selector 0xE writes Y shifted left by one (zero fill, mod 256) and writes flag equal to bit 7 of Y.
- R7: Selectors 0x8–0xD and 0xF raise neither `res_we` nor `flag_we`; `done` still pulses.
- R8: An operation accepted at a clock edge shows `done`, write enables and data in the next cycle only; a cycle without `op_valid` produces no `done` and no write enable in the following cycle.
- R9: When X index is 15 and the operation writes a flag (selectors 0x4–0x7, 0xE), `res_we` stays low and only the flag is written; for selectors 0x0–0x3 with X index 15 the result is written to index 15 normally.
- R10: While reset is held, `done`, `res_we` and `flag_we` are low.
- R11: `res_idx` equals the X index of the accepted operation; `flag_data` is always 0x00 or 0x01 when `flag_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation selector (instruction low nibble) |
| x_idx | input | 4 | Register index of X (destination) |
| x_val | input | 8 | Current value of X |
| y_val | input | 8 | Current value of Y |
| done | output | 1 | One-cycle pulse for each accepted operation |
| res_we | output | 1 | Write request for register `res_idx` |
| res_idx | output | 4 | Destination register index |
| res_data | output | 8 | Value to write to the destination |
| flag_we | output | 1 | Write request for register 15 |
| flag_data | output | 8 | Flag value, 0x00 or 0x01 |

## Verification
Random operands are drawn for every supported selector. For add and the subtractions they are mixed with directed pairs at the carry and borrow edges: 0xFF+0x01, 0x80+0x80, and equal operands. These pairs show whether the flag follows a carry or a no-borrow rule, and they catch a flag inverted at exactly X = Y. For the shifts, Y and X are given different bit 0 and bit 7 values, which shows whether the operand and the flag come from Y rather than from X. The destination index 15 is run with both flag-writing and logic selectors, which separates the suppressed result write from the normal one. Back-to-back operations and idle gaps show whether each pulse belongs to exactly one accepted operation.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;

  typedef enum logic [3:0] {
    OP_MOV  = 4'h0,
    OP_OR   = 4'h1,
    OP_AND  = 4'h2,
    OP_XOR  = 4'h3,
    OP_ADD  = 4'h4,
    OP_SUB  = 4'h5,
    OP_SHR  = 4'h6,
    OP_RSUB = 4'h7,
    OP_SHL  = 4'hE
  } alu_op_e;

  typedef struct packed {
    logic supported;
    logic makes_flag;
  } op_class_t;
endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
(
  input  logic [3:0] sel,
  output op_class_t  cls
);
  always_comb begin
    cls = '0;
    unique case (sel)
      OP_MOV, OP_OR, OP_AND, OP_XOR: cls.supported = 1'b1;
      OP_ADD, OP_SUB, OP_SHR, OP_RSUB, OP_SHL: begin
        cls.supported  = 1'b1;
        cls.makes_flag = 1'b1;
      end
      default: cls = '0;
    endcase
  end
endmodule

// File: rtl/byte_alu_datapath.sv
module byte_alu_datapath
  import byte_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [3:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         flag
);
  logic [W:0] sum_ext, diff_ab, diff_ba;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign diff_ab = {1'b0, a} - {1'b0, b};
  assign diff_ba = {1'b0, b} - {1'b0, a};

  always_comb begin
    result = '0;
    flag   = 1'b0;
    unique case (sel)
      OP_MOV:  result = b;
      OP_OR:   result = a | b;
      OP_AND:  result = a & b;
      OP_XOR:  result = a ^ b;
      OP_ADD:  begin result = sum_ext[W-1:0]; flag = sum_ext[W];  end
      OP_SUB:  begin result = diff_ab[W-1:0]; flag = ~diff_ab[W]; end
      OP_RSUB: begin result = diff_ba[W-1:0]; flag = ~diff_ba[W]; end
      OP_SHR:  begin result = {1'b0, b[W-1:1]}; flag = b[0]; end
      OP_SHL:  begin result = {b[W-2:0], 1'b0}; flag = b[W-1]; end
      default: begin result = '0; flag = 1'b0; end
    endcase
  end
endmodule

// File: rtl/byte_alu_commit.sv
module byte_alu_commit #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          wr_res,
  input  logic          wr_flag,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  res,
  input  logic          flag,
  output logic          done,
  output logic          res_we,
  output logic [IW-1:0] res_idx,
  output logic [W-1:0]  res_data,
  output logic          flag_we,
  output logic [W-1:0]  flag_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      res_we    <= 1'b0;
      flag_we   <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
      flag_data <= '0;
    end else begin
      done    <= take;
      res_we  <= take & wr_res;
      flag_we <= take & wr_flag;
      if (take) begin
        res_idx   <= idx;
        res_data  <= res;
        flag_data <= {{(W-1){1'b0}}, flag};
      end
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [IW-1:0] x_idx,
  input  logic [W-1:0]  x_val,
  input  logic [W-1:0]  y_val,
  output logic          done,
  output logic          res_we,
  output logic [IW-1:0] res_idx,
  output logic [W-1:0]  res_data,
  output logic          flag_we,
  output logic [W-1:0]  flag_data
);
  localparam logic [IW-1:0] FLAG_REG = IW'((1 << IW) - 1);

  op_class_t      cls;
  logic [W-1:0]   alu_res;
  logic           alu_flag;
  logic           hits_flag_reg;
  logic           want_res;

  byte_alu_decode u_dec (
    .sel (op_sel),
    .cls (cls)
  );

  byte_alu_datapath #(.W(W)) u_dp (
    .sel    (op_sel),
    .a      (x_val),
    .b      (y_val),
    .result (alu_res),
    .flag   (alu_flag)
  );

  // Flag has priority over the result when both land on the flag register.
  assign hits_flag_reg = (x_idx == FLAG_REG);
  assign want_res      = cls.supported & ~(cls.makes_flag & hits_flag_reg);

  byte_alu_commit #(.W(W), .IW(IW)) u_cm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (op_valid),
    .wr_res    (want_res),
    .wr_flag   (cls.makes_flag),
    .idx       (x_idx),
    .res       (alu_res),
    .flag      (alu_flag),
    .done      (done),
    .res_we    (res_we),
    .res_idx   (res_idx),
    .res_data  (res_data),
    .flag_we   (flag_we),
    .flag_data (flag_data)
  );
endmodule

// File: rtl/byte_alu_checker.sv
module byte_alu_checker #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_sel,
  input logic [IW-1:0] x_idx,
  input logic [W-1:0]  x_val,
  input logic [W-1:0]  y_val,
  input logic          done,
  input logic          res_we,
  input logic [IW-1:0] res_idx,
  input logic [W-1:0]  res_data,
  input logic          flag_we,
  input logic [W-1:0]  flag_data
);
  localparam logic [IW-1:0] FREG = IW'((1 << IW) - 1);

  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= rst_n;

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
    op_valid |=> done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
    !op_valid |=> (!done && !res_we && !flag_we)); // R8
  AST_UNSUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
    (op_valid && op_sel >= 4'h8 && op_sel != 4'hE) |=> (!res_we && !flag_we)); // R7
  AST_LOGIC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
    (op_valid && op_sel <= 4'h3) |=> !flag_we); // R1
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
    (op_valid && op_sel == 4'h4 && x_idx != FREG) |=>
      (res_data == W'($past(x_val) + $past(y_val)))); // R2
  AST_VF_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && res_idx == FREG) |-> !flag_we); // R9
  AST_FLAG_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (flag_data <= W'(1))); // R11
  AST_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n || !seen_edge)
    op_valid |=> (res_idx == $past(x_idx))); // R11
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (!done && !res_we && !flag_we)); // R10
endmodule

bind byte_alu byte_alu_checker #(.W(W), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_sel    (op_sel),
  .x_idx     (x_idx),
  .x_val     (x_val),
  .y_val     (y_val),
  .done      (done),
  .res_we    (res_we),
  .res_idx   (res_idx),
  .res_data  (res_data),
  .flag_we   (flag_we),
  .flag_data (flag_data)
);

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_sel;
  logic [3:0] x_idx;
  logic [7:0] x_val, y_val;
  logic       done, res_we, flag_we;
  logic [3:0] res_idx;
  logic [7:0] res_data, flag_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  byte_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .x_idx(x_idx), .x_val(x_val), .y_val(y_val), .done(done),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
    .flag_we(flag_we), .flag_data(flag_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] s, input logic [3:0] xi);
    if (xi == 4'hF && (s inside {4'h4, 4'h5, 4'h6, 4'h7, 4'hE})) return "R9";
    case (s)
      4'h0, 4'h1, 4'h2, 4'h3: return "R1";
      4'h4: return "R2";
      4'h5: return "R3";
      4'h7: return "R4";
      4'h6: return "R5";
      4'hE: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Reference model: {res_we, res_data, flag_we, flag}
  function automatic logic [17:0] model(input logic [3:0] s, input logic [3:0] xi,
                                        input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic f = 1'b0, rw = 1'b0, fw = 1'b0;
    int t;
    case (s)
      4'h0: begin r = b;     rw = 1; end
      4'h1: begin r = a | b; rw = 1; end
      4'h2: begin r = a & b; rw = 1; end
      4'h3: begin r = a ^ b; rw = 1; end
      4'h4: begin t = int'(a) + int'(b); r = t[7:0]; f = (t > 255); rw = 1; fw = 1; end
      4'h5: begin r = a - b; f = (a >= b); rw = 1; fw = 1; end
      4'h7: begin r = b - a; f = (b >= a); rw = 1; fw = 1; end
      4'h6: begin r = b >> 1; f = b[0]; rw = 1; fw = 1; end
      4'hE: begin r = b << 1; f = b[7]; rw = 1; fw = 1; end
      default: ;
    endcase
    if (fw && xi == 4'hF) rw = 0;
    return {rw, r, fw, 7'b0, f};
  endfunction

  logic [3:0] p_sel, p_idx;
  logic [7:0] p_x, p_y;
  bit         p_act = 0;

  task automatic check_prev();
    logic [17:0] e;
    string rq;
    if (!p_act) begin
      chk(done == 1'b0, "R8", "idle done", int'(done), 0);
      chk(res_we == 1'b0 && flag_we == 1'b0, "R8", "idle we",
          int'({res_we, flag_we}), 0);
      return;
    end
    e  = model(p_sel, p_idx, p_x, p_y);
    rq = req_of(p_sel, p_idx);
    chk(done == 1'b1, "R8", "done", int'(done), 1);
    chk(res_we == e[17], rq, "res_we", int'(res_we), int'(e[17]));
    if (e[17]) begin
      chk(res_data == e[16:9], rq, "res_data", int'(res_data), int'(e[16:9]));
      chk(res_idx == p_idx, "R11", "res_idx", int'(res_idx), int'(p_idx));
    end
    chk(flag_we == e[8], rq, "flag_we", int'(flag_we), int'(e[8]));
    if (e[8]) chk(flag_data == e[7:0], rq, "flag_data", int'(flag_data), int'(e[7:0]));
  endtask

  task automatic step(input bit v, input logic [3:0] s, input logic [3:0] xi,
                      input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    check_prev();
    op_valid = v; op_sel = s; x_idx = xi; x_val = a; y_val = b;
    p_act = v; p_sel = s; p_idx = xi; p_x = a; p_y = b;
  endtask

  function automatic logic [3:0] rand_sel();
    logic [3:0] pick [9] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE};
    return pick[$urandom_range(0, 8)];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; op_valid = 0; op_sel = 0; x_idx = 0; x_val = 0; y_val = 0;
    op_valid = 1; op_sel = 4'h4; x_val = 8'hFF; y_val = 8'hFF;
    repeat (3) @(negedge clk);
    chk(!done && !res_we && !flag_we, "R10", "reset outputs",
        int'({done, res_we, flag_we}), 0);
    op_valid = 0;
    @(negedge clk);
    rst_n = 1;
    // R2 carry edges
    step(1, 4'h4, 4'h2, 8'hFF, 8'h01);
    step(1, 4'h4, 4'h2, 8'h80, 8'h80);
    step(1, 4'h4, 4'h2, 8'h7F, 8'h80);
    // R3 / R4 borrow edges, equal operands
    step(1, 4'h5, 4'h3, 8'h40, 8'h40);
    step(1, 4'h5, 4'h3, 8'h00, 8'h01);
    step(1, 4'h7, 4'h3, 8'h55, 8'h55);
    step(1, 4'h7, 4'h3, 8'h10, 8'h05);
    // R5 / R6 operand from Y, not X
    step(1, 4'h6, 4'h4, 8'hFE, 8'h81);
    step(1, 4'hE, 4'h4, 8'h7F, 8'h80);
    step(1, 4'hE, 4'h4, 8'h80, 8'h41);
    // R1 logic and copy, including flag register destination
    step(1, 4'h0, 4'h1, 8'h12, 8'hAB);
    step(1, 4'h3, 4'hF, 8'hF0, 8'h3C);
    // R9 flag-producing op aimed at register 15
    step(1, 4'h4, 4'hF, 8'hF0, 8'h20);
    step(1, 4'h5, 4'hF, 8'h01, 8'h02);
    // R7 unsupported selectors
    for (int s = 8; s <= 15; s++) if (s != 14) step(1, 4'(s), 4'h5, 8'hAA, 8'h55);
    // R8 idle gap
    step(0, 4'h4, 4'h1, 8'hFF, 8'hFF);
    step(0, 4'h0, 4'h1, 8'h00, 8'h00);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit v = ($urandom_range(0, 9) != 0);
      logic [3:0] s = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(8, 13)) : rand_sel();
      step(v, s, 4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom));
    end
    step(0, 4'h0, 4'h0, 8'h00, 8'h00);
    @(negedge clk);
    check_prev();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule